// File: doc/BRIEF.md
# SAR ADC Conversion and Readback Host

This block is the host side of a four-wire serial link to a multichannel successive-approximation converter, used in the mode with no busy indicator. A one-clock start request with a 14-bit configuration word makes the host raise the convert line. The host then counts a fixed number of system clocks, because a conversion, once begun, finishes on its own and gives no pin to watch. When the count ends, the host lowers the convert line and runs one serial burst in SPI mode 0. During that burst it sends the new configuration word on the data-out line and, on the same clocks, collects the previous conversion's 16-bit result from the data-in line.

A parameter turns on configuration readback. With it on, the burst grows from 16 to 30 clocks, and the 14 configuration bits the converter echoes after the result LSB are delivered beside the result. A configuration word sent in one burst governs a later conversion. The result returned at any moment therefore belongs to the conversion before the one currently being set up, and software pairs results with channels on that basis.

The finished result is held on the output port and marked by a one-clock valid strobe. The host then goes back to idle and waits for the next start. The cycle period is therefore at least the conversion time plus the burst time.

Top module: `sar_cnv_host`

States: IDLE (waiting for start), CONV (convert line high, conversion timer running), SCK_LO (serial clock low half), SCK_HI (serial clock high half), DONE (one clock with valid high). Transitions: IDLE->CONV on start; CONV->SCK_LO when the conversion timer expires; SCK_LO->SCK_HI when the half-period timer expires (data-in is sampled here); SCK_HI->SCK_LO when the half-period timer expires and bits remain (data-out advances here); SCK_HI->DONE when the half-period timer expires on the last bit; DONE->IDLE unconditionally.

## Requirements
- R1: While reset is asserted and afterwards in IDLE, the convert line, the serial clock and the valid strobe are all low.
- R2: A start seen in IDLE raises the convert line on the next clock, and it stays high for exactly CONV_CYCLES system clocks before it falls.
- R3: A start that arrives while a conversion or a burst is in progress is ignored: it does not change that burst's configuration word, its timing or its result.
- R4: The serial clock idles low (mode 0) and is never high while the convert line is high. Each burst gives exactly N pulses, each SCK_HALF clocks high after SCK_HALF clocks low, where N is 30 with readback on and 16 with it off.
- R5: The configuration word goes out MSB first on the data-out line. Its MSB is present when the convert line falls, and the line changes only on a falling serial-clock edge. All 14 bits are sent in every burst, and the line is low for any rising edges after the 14th.
- R6: The data-in line is sampled on every rising serial-clock edge. The result output is the first 16 sampled bits, with the first sample as bit 15.
- R7: With readback on, the configuration output is sampled bits 17 to 30, with bit 17 as bit 13. With readback off, the configuration output is zero.
- R8: The valid strobe is high for exactly one clock, 1+CONV_CYCLES+2*N*SCK_HALF clock edges after the edge that sampled start. The result and configuration outputs hold their values until the next burst starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock request to begin a convert-and-read cycle |
| cfg_in | input | CFG_W | Configuration word captured with start |
| res_data | output | RES_W | Last conversion result |
| res_cfg | output | CFG_W | Echoed configuration word (zero if readback off) |
| res_valid | output | 1 | One-clock strobe when a new result is ready |
| adc_cnv | output | 1 | Convert line to the converter |
| adc_sck | output | 1 | Serial clock, mode 0 |
| adc_din | output | 1 | Configuration data to the converter |
| adc_sdo | input | 1 | Serial data from the converter |

## Verification
The valid strobe is due 1+CONV_CYCLES+2*N*SCK_HALF edges after the start edge, which is 133 edges for the readback instance and 77 for the plain one in the bench setup. The bench counts rising edges from the start edge and samples on falling edges, so it records the exact edge at which each strobe is seen and how long the convert line stays high. The behavioural converter model counts serial-clock edges in the same way. The result, readback and captured configuration are compared only after both strobes are past, so that the hold behaviour is checked as well.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_DONE
    } host_st_e;
endpackage

// File: rtl/sar_host_timer.sv
module sar_host_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sar_host_shift.sv
module sar_host_shift #(
    parameter int CFG_W = 14,
    parameter int RX_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg,
    input  logic             shift_tx,
    input  logic             sample,
    input  logic             sdo_in,
    output logic             din,
    output logic [RX_W-1:0]  rx
);
    logic [CFG_W-1:0] tx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tx <= '0;
        else if (load)
            tx <= cfg;
        else if (shift_tx)
            tx <= {tx[CFG_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx <= '0;
        else if (sample)
            rx <= {rx[RX_W-2:0], sdo_in};
    end

    assign din = tx[CFG_W-1];

    // R6: a sample and a data-out advance never share a clock
    assert_sample_shift_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && shift_tx));

    // R3: a new word is never loaded in the middle of a burst
    assert_no_load_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && (shift_tx || sample)));
endmodule

// File: rtl/sar_cnv_host.sv
module sar_cnv_host
    import sar_host_pkg::*;
#(
    parameter int CONV_CYCLES = 64,
    parameter int SCK_HALF    = 2,
    parameter int CFG_RB      = 1,
    parameter int RES_W       = 16,
    parameter int CFG_W       = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [RES_W-1:0] res_data,
    output logic [CFG_W-1:0] res_cfg,
    output logic             res_valid,
    output logic             adc_cnv,
    output logic             adc_sck,
    output logic             adc_din,
    input  logic             adc_sdo
);
    localparam int NBITS = RES_W + ((CFG_RB != 0) ? CFG_W : 0);
    localparam int TMAX  = (CONV_CYCLES > SCK_HALF) ? CONV_CYCLES : SCK_HALF;
    localparam int TW    = $clog2(TMAX + 1);
    localparam int BW    = $clog2(NBITS + 1);

    host_st_e          st, st_nx;
    logic [BW-1:0]     bit_cnt;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;
    logic              last_bit, do_sample, do_shift, do_load;
    logic [NBITS-1:0]  rx;
    logic              cnv_q, sck_q, vld_q;

    assign last_bit  = (bit_cnt == BW'(NBITS - 1));
    assign do_load   = (st == ST_IDLE) && start;
    assign do_sample = (st == ST_SCK_LO) && tmr_exp;
    assign do_shift  = (st == ST_SCK_HI) && tmr_exp && !last_bit;

    // next state and timer control
    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE: if (start) begin
                st_nx    = ST_CONV;
                tmr_load = 1'b1;
                tmr_val  = TW'(CONV_CYCLES - 1);
            end
            ST_CONV: if (tmr_exp) begin
                st_nx    = ST_SCK_LO;
                tmr_load = 1'b1;
                tmr_val  = TW'(SCK_HALF - 1);
            end
            ST_SCK_LO: if (tmr_exp) begin
                st_nx    = ST_SCK_HI;
                tmr_load = 1'b1;
                tmr_val  = TW'(SCK_HALF - 1);
            end
            ST_SCK_HI: if (tmr_exp) begin
                st_nx    = last_bit ? ST_DONE : ST_SCK_LO;
                tmr_load = !last_bit;
                tmr_val  = TW'(SCK_HALF - 1);
            end
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // registered outputs and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_q   <= 1'b0;
            sck_q   <= 1'b0;
            vld_q   <= 1'b0;
            bit_cnt <= '0;
        end else begin
            cnv_q <= (st_nx == ST_CONV);
            sck_q <= (st_nx == ST_SCK_HI);
            vld_q <= (st_nx == ST_DONE);
            if (do_load)
                bit_cnt <= '0;
            else if (do_shift)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    sar_host_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sar_host_shift #(.CFG_W(CFG_W), .RX_W(NBITS)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .cfg      (cfg_in),
        .shift_tx (do_shift),
        .sample   (do_sample),
        .sdo_in   (adc_sdo),
        .din      (adc_din),
        .rx       (rx)
    );

    generate
        if (CFG_RB != 0) begin : g_rb
            assign res_data = rx[NBITS-1 -: RES_W];
            assign res_cfg  = rx[CFG_W-1:0];
        end else begin : g_norb
            assign res_data = rx;
            assign res_cfg  = '0;
        end
    endgenerate

    assign adc_cnv   = cnv_q;
    assign adc_sck   = sck_q;
    assign res_valid = vld_q;

    // R1: idle keeps the link quiet
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!adc_sck && !res_valid));

    // R2: the convert line only falls once the conversion timer has run out
    assert_cnv_timed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv) |-> $past(tmr_exp));

    // R3: a start during a burst does not restart a conversion
    assert_ignore_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_SCK_LO || st == ST_SCK_HI) && start) |=> (st != ST_CONV));

    // R4: the serial clock never runs while the convert line is high
    assert_no_sck_in_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv |-> !adc_sck);

    // R5: configuration data holds while the serial clock stays high
    assert_din_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sck && $past(adc_sck)) |-> $stable(adc_din));

    // R7: a result is only flagged after the full burst length
    assert_full_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (bit_cnt == BW'(NBITS - 1)));

    // R8: the valid strobe lasts one clock
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

// File: tb/tb_sar_cnv_host.sv
`timescale 1ns/1ps

module tb_adc_model #(
    parameter int RB = 1
) (
    input  logic        cnv,
    input  logic        sck,
    input  logic        din,
    output logic        sdo,
    input  logic [15:0] res,
    output logic [13:0] got_cfg,
    output int          rise_n,
    output int          fall_n,
    output int          late_din
);
    localparam int NTOT = (RB != 0) ? 30 : 16;
    logic [29:0] sh;
    logic [13:0] cap;
    logic [13:0] last_cfg;

    initial begin
        sdo = 1'b0; sh = '0; cap = '0; last_cfg = '0; got_cfg = '0;
        rise_n = 0; fall_n = 0; late_din = 0;
    end

    always @(negedge cnv) begin
        sh = {res, ((RB != 0) ? last_cfg : 14'h0)};
        sdo = sh[29];
        rise_n = 0; fall_n = 0; late_din = 0; cap = '0;
    end

    always @(posedge cnv) sdo = 1'b0;

    always @(posedge sck) if (cnv === 1'b0) begin
        if (rise_n < 14) cap = {cap[12:0], din};
        else if (din) late_din = late_din + 1;
        rise_n = rise_n + 1;
        if (rise_n == 14) begin
            got_cfg = cap;
            last_cfg = cap;
        end
    end

    always @(negedge sck) if (cnv === 1'b0) begin
        fall_n = fall_n + 1;
        sh = {sh[28:0], 1'b0};
        sdo = (fall_n >= NTOT) ? 1'b0 : sh[29];
    end
endmodule

module tb_sar_cnv_host;
    localparam int C     = 12;
    localparam int H     = 2;
    localparam int NA    = 30;
    localparam int NB    = 16;
    localparam int LAT_A = 1 + C + 2 * NA * H;
    localparam int LAT_B = 1 + C + 2 * NB * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [13:0] cfg_in = '0;
    logic [15:0] res_pat = '0;

    logic [15:0] data_a, data_b;
    logic [13:0] rbc_a, rbc_b, got_a, got_b;
    logic        vld_a, vld_b, cnv_a, cnv_b, sck_a, sck_b, din_a, din_b, sdo_a, sdo_b;
    int          rise_a, rise_b, fall_a, fall_b, late_a, late_b;

    int total = 0;
    int bad = 0;
    logic [13:0] prev_cfg = '0;

    always #4 clk = ~clk;

    sar_cnv_host #(.CONV_CYCLES(C), .SCK_HALF(H), .CFG_RB(1)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .res_data(data_a), .res_cfg(rbc_a), .res_valid(vld_a),
        .adc_cnv(cnv_a), .adc_sck(sck_a), .adc_din(din_a), .adc_sdo(sdo_a));

    sar_cnv_host #(.CONV_CYCLES(C), .SCK_HALF(H), .CFG_RB(0)) dut_s (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .res_data(data_b), .res_cfg(rbc_b), .res_valid(vld_b),
        .adc_cnv(cnv_b), .adc_sck(sck_b), .adc_din(din_b), .adc_sdo(sdo_b));

    tb_adc_model #(.RB(1)) adc_a (.cnv(cnv_a), .sck(sck_a), .din(din_a), .sdo(sdo_a),
        .res(res_pat), .got_cfg(got_a), .rise_n(rise_a), .fall_n(fall_a), .late_din(late_a));
    tb_adc_model #(.RB(0)) adc_b (.cnv(cnv_b), .sck(sck_b), .din(din_b), .sdo(sdo_b),
        .res(res_pat), .got_cfg(got_b), .rise_n(rise_b), .fall_n(fall_b), .late_din(late_b));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [13:0] cfg, input logic [15:0] res, input bit mid);
        int e = 0, va = 0, vb = 0, ea = 0, eb = 0, ca = 0, cb = 0;
        @(negedge clk);
        start = 1'b1; cfg_in = cfg; res_pat = res;
        while (e < LAT_A + 3) begin
            @(posedge clk);
            e++;
            @(negedge clk);
            if (e == 1) start = 1'b0;
            if (mid && (e == 4 || e == 40)) begin start = 1'b1; cfg_in = ~cfg; end
            if (mid && (e == 5 || e == 41)) begin start = 1'b0; cfg_in = cfg; end
            if (cnv_a) ca++;
            if (cnv_b) cb++;
            if (vld_a) begin va++; ea = e; end
            if (vld_b) begin vb++; eb = e; end
        end
        chk("R2 cnv high a", 32'(ca), 32'(C));
        chk("R2 cnv high b", 32'(cb), 32'(C));
        chk("R8 valid count a", 32'(va), 32'd1);
        chk("R8 valid count b", 32'(vb), 32'd1);
        chk("R8 latency a", 32'(ea), 32'(LAT_A));
        chk("R8 latency b", 32'(eb), 32'(LAT_B));
        chk("R4 rising a", 32'(rise_a), 32'(NA));
        chk("R4 falling a", 32'(fall_a), 32'(NA));
        chk("R4 rising b", 32'(rise_b), 32'(NB));
        chk("R4 falling b", 32'(fall_b), 32'(NB));
        chk("R5 cfg sent a", 32'(got_a), 32'(cfg));
        chk("R5 cfg sent b", 32'(got_b), 32'(cfg));
        chk("R5 din low late a", 32'(late_a), 32'd0);
        chk("R5 din low late b", 32'(late_b), 32'd0);
        chk("R6 result a", 32'(data_a), 32'(res));
        chk("R6 result b", 32'(data_b), 32'(res));
        chk("R7 readback a", 32'(rbc_a), 32'(prev_cfg));
        chk("R7 readback off b", 32'(rbc_b), 32'd0);
        if (mid) chk("R3 start ignored", 32'(got_a), 32'(cfg));
        prev_cfg = cfg;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        chk("R1 reset cnv", 32'({cnv_a, cnv_b}), 32'd0);
        chk("R1 reset sck", 32'({sck_a, sck_b}), 32'd0);
        chk("R1 reset valid", 32'({vld_a, vld_b}), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle quiet", 32'({cnv_a, cnv_b, sck_a, sck_b, vld_a, vld_b}), 32'd0);

        for (int i = 0; i < 14; i++) begin
            xfer(14'(1) << i, (i % 2 == 0) ? (16'(1) << i) : ~(16'(1) << i), (i % 4) == 0);
        end
        xfer(14'h3FFF, 16'h8000, 1'b0);
        xfer(14'h0000, 16'h4000, 1'b1);
        xfer(14'h2AAA, 16'hFFFF, 1'b0);
        xfer(14'h1555, 16'h0000, 1'b0);
        lf = 16'hACE1;
        for (int k = 0; k < 10; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            xfer(lf[13:0] ^ 14'h0A5F, lf, (k % 3) == 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule